// File: doc/BRIEF.md
# Beep and Speaker Tone Generator

This block drives one speaker bit from two sources. The first is a standard beep: a high-to-low transition on an active-low trigger starts a one-shot timer that gates a 1920 Hz square tone for half a second. The beep then ends by itself. The second is a speaker bit that software holds in a control register and toggles at an audible rate. Software can make any pitch and any length of sound this way. The speaker output is the OR of the gated tone and the software bit.

Three small state machines make up the block:

- **Trigger edge detector.** It has states `TRIG_LOW` and `TRIG_HIGH`. The transition *arm* goes from `TRIG_LOW` to `TRIG_HIGH` when the trigger is seen high. The transition *fire* goes from `TRIG_HIGH` to `TRIG_LOW` when the trigger is seen low, and it emits a one-cycle start pulse. The detector leaves reset in `TRIG_LOW`, so a trigger that is already low at reset release does not start a beep.
- **One-shot timer.** It has states `OS_IDLE` and `OS_SOUNDING`.
  - *launch*: `OS_IDLE` to `OS_SOUNDING` on a start pulse.
  - *retrigger*: a start pulse while in `OS_SOUNDING` reloads the full duration.
  - *count*: the timer stays in `OS_SOUNDING` and decrements.
  - *expire*: `OS_SOUNDING` to `OS_IDLE` when the count reaches zero.
- **Tone phase machine.** It has states `PH_REST`, `PH_HIGH` and `PH_LOW`.
  - *start*: any state to `PH_HIGH` on a start pulse, with the divider cleared.
  - *flip*: `PH_HIGH` to `PH_LOW`, or back, after each half period.
  - *rest*: any state to `PH_REST` while the one-shot is idle.

The tone half period is round(CLK_HZ / (2 × TONE_HZ)) clock cycles. The beep length is CLK_HZ / BEEP_DIV cycles, which is half a second with the default BEEP_DIV of 2.

Top module: `spk_beep_top`

## Requirements
- R1: While reset is asserted, and in the first cycles after it is released with no trigger and no write, spk_out is 0.
- R2: When beep_trig_n is sampled low at a clock edge, having been sampled high at the previous edge, the beep starts. spk_out is 1 in the cycle after that edge.
- R3: While a beep sounds, its tone is a square wave. It stays high for HALF clock cycles from the start edge, then alternates every HALF cycles, where HALF = round(CLK_HZ/(2*TONE_HZ)).
- R4: A beep lasts exactly CLK_HZ/BEEP_DIV cycles counted from its start edge. The tone then stops and contributes nothing to spk_out.
- R5: A new high-to-low trigger transition during a beep restarts both the full duration and the tone phase from its own edge.
- R6: Holding beep_trig_n low for many cycles starts only one beep. No further beep starts until the trigger returns high and falls again.
- R7: A clock edge with ctrl_wr_en = 1 loads the speaker bit from ctrl_wr_data bit SPK_BIT (default 6). spk_out reflects it from the next cycle. An edge with ctrl_wr_en = 0 leaves the bit unchanged.
- R8: spk_out is the OR of the software speaker bit and the beep tone. With the bit set, spk_out stays 1 through a whole beep.
- R9: ctrl_wr_data bits other than SPK_BIT have no effect on spk_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| beep_trig_n | input | 1 | Active-low beep trigger, synchronous to clk |
| ctrl_wr_en | input | 1 | Control register write strobe |
| ctrl_wr_data | input | CTRL_W | Control register write data; bit SPK_BIT is the speaker bit |
| spk_out | output | 1 | Speaker drive bit |

## Verification
The assertions assume that beep_trig_n, ctrl_wr_en and ctrl_wr_data are synchronous to clk and never unknown once reset is released. In particular, the edge detector's single-start property relies on the trigger being a clean synchronous level. The stimulus meets this by changing every input only on the falling clock edge, from 0 or 1 values. Random trigger pulses are kept rare, so most beeps both overlap (retrigger) and expire naturally. Random writes mix set and clear values of the speaker bit with arbitrary values in the other bits.

// File: rtl/spk_pkg.sv
package spk_pkg;

    typedef enum logic {
        TRIG_LOW  = 1'b0,
        TRIG_HIGH = 1'b1
    } trig_state_e;

    typedef enum logic {
        OS_IDLE     = 1'b0,
        OS_SOUNDING = 1'b1
    } os_state_e;

    typedef enum logic [1:0] {
        PH_REST = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } tone_phase_e;

endpackage

// File: rtl/spk_trig_edge.sv
module spk_trig_edge
    import spk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig_n,
    output logic fire
);

    trig_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TRIG_LOW;
        else        state_q <= state_d;
    end

    // next state: arm on high, fire on low
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRIG_LOW:  if (trig_n)  state_d = TRIG_HIGH;
            TRIG_HIGH: if (!trig_n) state_d = TRIG_LOW;
            default:   state_d = TRIG_LOW;
        endcase
    end

    // outputs
    always_comb begin
        fire = (state_q == TRIG_HIGH) && !trig_n;
    end

    // R6: a held-low trigger cannot fire on consecutive edges
    a_r6_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

endmodule

// File: rtl/spk_oneshot.sv
module spk_oneshot
    import spk_pkg::*;
#(
    parameter int unsigned DUR = 4_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);

    localparam int unsigned CW = (DUR > 2) ? $clog2(DUR) : 1;
    localparam logic [CW-1:0] LAST = CW'(DUR - 1);

    os_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // launch / retrigger / count / expire
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            OS_IDLE: begin
                if (start) begin
                    state_d = OS_SOUNDING;
                    cnt_d   = LAST;
                end
            end
            OS_SOUNDING: begin
                if (start) begin
                    cnt_d = LAST;
                end else if (cnt_q == '0) begin
                    state_d = OS_IDLE;
                end else begin
                    cnt_d = cnt_q - CW'(1);
                end
            end
            default: begin
                state_d = OS_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        active = (state_q == OS_SOUNDING);
    end

    // R2 / R5: every start leaves the timer sounding with a full count
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (active && cnt_q == LAST));

    // R4: the count falls by one each cycle while sounding
    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !start && cnt_q != '0) |=> (active && cnt_q == $past(cnt_q) - CW'(1)));

    // R4: at zero the beep ends
    a_r4_expire: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !start && cnt_q == '0) |=> !active);

    // R4: idle stays idle without a start
    a_r4_no_self_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !start) |=> !active);

endmodule

// File: rtl/spk_tone_div.sv
module spk_tone_div
    import spk_pkg::*;
#(
    parameter int unsigned HALF = 2083
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic tone
);

    localparam int unsigned HW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [HW-1:0] LASTH = HW'(HALF - 1);

    tone_phase_e   phase_q, phase_d;
    logic [HW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_REST;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    // start / flip / rest
    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        if (start) begin
            phase_d = PH_HIGH;
            cnt_d   = '0;
        end else if (!run) begin
            phase_d = PH_REST;
            cnt_d   = '0;
        end else begin
            unique case (phase_q)
                PH_REST: begin
                    phase_d = PH_REST;
                    cnt_d   = '0;
                end
                PH_HIGH, PH_LOW: begin
                    if (cnt_q == LASTH) begin
                        phase_d = (phase_q == PH_HIGH) ? PH_LOW : PH_HIGH;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + HW'(1);
                    end
                end
                default: begin
                    phase_d = PH_REST;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        tone = (phase_q == PH_HIGH);
    end

    // R3: divider never passes its half period
    a_r3_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LASTH);

    // R3: phase holds until the half period elapses
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !start && phase_q != PH_REST && cnt_q != LASTH) |=> $stable(phase_q));

    // R3: high half is followed by low half
    a_r3_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !start && phase_q == PH_HIGH && cnt_q == LASTH) |=> (phase_q == PH_LOW));

    // R2 / R5: a start always opens a fresh high half
    a_r5_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (phase_q == PH_HIGH && cnt_q == '0));

endmodule

// File: rtl/spk_ctrl_bit.sv
module spk_ctrl_bit #(
    parameter int unsigned W   = 8,
    parameter int unsigned BIT = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         spk_bit
);

    logic [W-1:0] unused_wr_data;
    assign unused_wr_data = wr_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     spk_bit <= 1'b0;
        else if (wr_en) spk_bit <= wr_data[BIT];
    end

    // R7: no write, no change
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(spk_bit));

    // R7 / R9: a write takes only the speaker bit position
    a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (spk_bit == $past(wr_data[BIT])));

endmodule

// File: rtl/spk_beep_top.sv
module spk_beep_top #(
    parameter int unsigned CLK_HZ   = 8_000_000,
    parameter int unsigned TONE_HZ  = 1920,
    parameter int unsigned BEEP_DIV = 2,
    parameter int unsigned CTRL_W   = 8,
    parameter int unsigned SPK_BIT  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beep_trig_n,
    input  logic              ctrl_wr_en,
    input  logic [CTRL_W-1:0] ctrl_wr_data,
    output logic              spk_out
);

    localparam int unsigned HALF_CYC = (CLK_HZ + TONE_HZ) / (2 * TONE_HZ);
    localparam int unsigned BEEP_CYC = CLK_HZ / BEEP_DIV;

    logic start;
    logic active;
    logic tone;
    logic spk_bit;

    spk_trig_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_n (beep_trig_n),
        .fire   (start)
    );

    spk_oneshot #(.DUR(BEEP_CYC)) u_shot (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .active (active)
    );

    spk_tone_div #(.HALF(HALF_CYC)) u_tone (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .run   (active),
        .tone  (tone)
    );

    spk_ctrl_bit #(.W(CTRL_W), .BIT(SPK_BIT)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctrl_wr_en),
        .wr_data (ctrl_wr_data),
        .spk_bit (spk_bit)
    );

    assign spk_out = (active & tone) | spk_bit;

endmodule

// File: tb/sim_spk_beep_top.sv
module sim_spk_beep_top;

    localparam int CLK_HZ = 19200;
    localparam int HALF   = 5;      // round(19200 / 3840)
    localparam int DUR    = 9600;   // half a second at 19200 Hz

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       beep_trig_n = 1'b1;
    logic       ctrl_wr_en = 1'b0;
    logic [7:0] ctrl_wr_data = 8'h00;
    logic       spk_out;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;   // 50 MHz

    spk_beep_top #(.CLK_HZ(CLK_HZ)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .beep_trig_n  (beep_trig_n),
        .ctrl_wr_en   (ctrl_wr_en),
        .ctrl_wr_data (ctrl_wr_data),
        .spk_out      (spk_out)
    );

    // Reference model built from the requirements
    logic m_seen_high = 1'b0;
    int   m_left = 0;
    int   m_age  = 0;
    logic m_bit  = 1'b0;

    function automatic logic exp_out(input int left, input int age, input logic b);
        logic t;
        t = (left > 0) && (((age / HALF) % 2) == 0);
        return t | b;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_seen_high <= 1'b0;
            m_left <= 0;
            m_age  <= 0;
            m_bit  <= 1'b0;
        end else begin
            m_seen_high <= beep_trig_n;
            if (m_seen_high && !beep_trig_n) begin
                m_left <= DUR;
                m_age  <= 0;
            end else if (m_left > 0) begin
                m_left <= m_left - 1;
                m_age  <= m_age + 1;
            end
            if (ctrl_wr_en) m_bit <= ctrl_wr_data[6];
        end
    end

    task automatic chk(input string tag, input logic act, input logic expv);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, expv, $time);
        end
    endtask

    // Continuous comparison each cycle: R3 tone, R4 stop, R7 bit, R8 OR
    always @(negedge clk) begin
        if (rst_n) begin
            if (m_left > 0) chk(m_bit ? "R8 model" : "R3 model", spk_out, exp_out(m_left, m_age, m_bit));
            else            chk(m_bit ? "R7 model" : "R4 model", spk_out, exp_out(m_left, m_age, m_bit));
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic trig_pulse();
        beep_trig_n = 1'b0;
        cyc(1);
        beep_trig_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] d, input logic en);
        ctrl_wr_en   = en;
        ctrl_wr_data = d;
        cyc(1);
        ctrl_wr_en = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        logic saw_high;
        void'($urandom(32'd20250));
        cyc(3);
        chk("R1 in reset", spk_out, 1'b0);
        rst_n = 1'b1;
        cyc(3);
        chk("R1 after reset", spk_out, 1'b0);

        // R2 / R3 / R4: single beep
        trig_pulse();
        chk("R2 start high", spk_out, 1'b1);
        cyc(HALF - 1);
        chk("R3 end of first high half", spk_out, 1'b1);
        cyc(1);
        chk("R3 first low half", spk_out, 1'b0);
        cyc(HALF);
        chk("R3 second high half", spk_out, 1'b1);
        cyc(DUR - 2 * HALF - 1);
        chk("R4 last beep cycle", spk_out, exp_out(1, DUR - 1, 1'b0));
        cyc(1);
        saw_high = 1'b0;
        for (int i = 0; i < 4 * HALF; i++) begin
            if (spk_out) saw_high = 1'b1;
            cyc(1);
        end
        chk("R4 silent after expiry", saw_high, 1'b0);

        // R6: held low gives one beep only
        beep_trig_n = 1'b0;
        cyc(1);
        chk("R6 held low starts", spk_out, 1'b1);
        cyc(DUR + 20);
        saw_high = 1'b0;
        for (int i = 0; i < 4 * HALF; i++) begin
            if (spk_out) saw_high = 1'b1;
            cyc(1);
        end
        chk("R6 no second beep while held", saw_high, 1'b0);
        beep_trig_n = 1'b1;
        cyc(5);

        // R5: retrigger extends
        trig_pulse();
        cyc(DUR - 50);
        trig_pulse();
        chk("R5 restart phase high", spk_out, 1'b1);
        cyc(100);
        saw_high = 1'b0;
        for (int i = 0; i < 2 * HALF; i++) begin
            if (spk_out) saw_high = 1'b1;
            cyc(1);
        end
        chk("R5 still sounding past first end", saw_high, 1'b1);
        cyc(DUR);
        chk("R5 ends after extended span", spk_out, 1'b0);

        // R7 / R9 / R8
        wr(8'h40, 1'b1);
        chk("R7 bit set", spk_out, 1'b1);
        wr(8'h00, 1'b0);
        chk("R7 write without enable ignored", spk_out, 1'b1);
        trig_pulse();
        cyc(HALF + 1);
        chk("R8 bit covers low half", spk_out, 1'b1);
        cyc(DUR);
        wr(8'hBF, 1'b1);
        chk("R9 other bits no effect", spk_out, 1'b0);
        wr(8'h40, 1'b1);
        chk("R7 bit set again", spk_out, 1'b1);
        wr(8'h00, 1'b1);
        chk("R7 bit cleared", spk_out, 1'b0);

        // Random phase
        for (int i = 0; i < 30000; i++) begin
            beep_trig_n  = ($urandom_range(0, 2999) != 0);
            ctrl_wr_en   = ($urandom_range(0, 19) == 0);
            ctrl_wr_data = 8'($urandom);
            cyc(1);
        end
        beep_trig_n = 1'b1;
        ctrl_wr_en  = 1'b0;
        cyc(10);
        summary();
    end

endmodule